// File: doc/BRIEF.md
# Interrupt Status and Mask Register Set

This block collects up to 32 event sources into one level-sensitive interrupt line. Each source has a status bit and a mask bit. A pulse on a hardware event input latches the matching status bit. Software sees and controls the bits through a small 32-bit register port with separate write and read strobes. Status bits are cleared by writing ones to them. The mask cannot be written directly. Three command addresses change it or the status instead: one unmasks sources, one masks them, and one forces status bits for test. Each command acts once and always reads back as zero.

Only the bit positions in the implemented pattern `0x0003_BFFF` exist. Every other position reads as zero and ignores events and writes. At reset all implemented sources are masked and no status is pending. The interrupt output follows the current status and mask, so it changes on the edge that changes either of them. The register set has no internal state machine, so no states or transitions are defined.

Register word addresses, taken from `wr_addr` and `rd_addr`: 0 = status, 1 = mask (read only), 2 = unmask command, 3 = mask command, 4 = force command. Addresses 5 to 7 are unused.

Top module: `evt_irq_ctrl`

## Requirements
- R1: `irq` is 1 exactly when some status bit is 1 and the mask bit at the same position is 0. It changes on the same clock edge as the status or mask update that causes the change.
- R2: A write to address 0 clears every implemented status bit whose `wr_data` bit is 1. Bits written with 0 keep their value.
- R3: Bit positions outside `0x0003_BFFF` always read as 0 in status and mask, and never cause `irq`. This holds even when an event, a force write or an unmask write sets those bit positions to 1.
- R4: Reset leaves status at 0, mask at `0x0003_BFFF`, `irq` at 0 and `rd_data` at 0. A write to address 1 leaves the mask unchanged.
- R5: A write to address 2 clears the mask bits whose `wr_data` bit is 1. A read of address 2 returns 0.
- R6: A write to address 3 sets the implemented mask bits whose `wr_data` bit is 1. A read of address 3 returns 0.
- R7: A write to address 4 sets the implemented status bits whose `wr_data` bit is 1. A read of address 4 returns 0.
- R8: An implemented status bit is 1 on the edge after its `hw_event` bit is sampled high, whether the source is masked or not.
- R9: When a hardware event and a clear write hit the same status bit on the same edge, the event wins and the bit stays 1.
- R10: A read with `rd_en` high puts the addressed register on `rd_data` at that edge. Addresses 5 to 7 read as 0. Without `rd_en`, `rd_data` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Registered read data |
| hw_event | input | 32 | Event pulses, one per source |
| irq | output | 1 | Level interrupt output |

## Verification
A write or an event sampled at edge N changes status and mask at edge N. `irq` follows at that same edge. A read strobed at edge N+1 returns the updated register after edge N+1. The bench drives the write in one cycle and the read in the next, then samples `rd_data` and `irq` at the falling edge after the read edge. By then every result due for that vector has settled. For hold and reset checks, the bench leaves `rd_en` low and samples after the edge that could have disturbed the value.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [2:0] {
        SEL_STATUS  = 3'd0,
        SEL_MASK    = 3'd1,
        SEL_UNMASK  = 3'd2,
        SEL_MASKSET = 3'd3,
        SEL_FORCE   = 3'd4
    } reg_sel_e;

    localparam int unsigned SEL_W = 3;
endpackage

// File: rtl/irqc_wr_decode.sv
module irqc_wr_decode
    import irqc_pkg::*;
(
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_addr,
    output logic             clr_stb,
    output logic             unmask_stb,
    output logic             maskset_stb,
    output logic             force_stb
);
    always_comb begin
        clr_stb     = 1'b0;
        unmask_stb  = 1'b0;
        maskset_stb = 1'b0;
        force_stb   = 1'b0;
        if (wr_en) begin
            unique case (wr_addr)
                SEL_STATUS:  clr_stb     = 1'b1;
                SEL_UNMASK:  unmask_stb  = 1'b1;
                SEL_MASKSET: maskset_stb = 1'b1;
                SEL_FORCE:   force_stb   = 1'b1;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/irqc_status_bits.sv
module irqc_status_bits #(
    parameter int unsigned      W     = 32,
    parameter logic [W-1:0]     VALID = 32'h0003_BFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_stb,
    input  logic         force_stb,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_event,
    output logic [W-1:0] status_q
);
    logic unused_rsvd_in;
    assign unused_rsvd_in = ^((wdata | hw_event) & ~VALID);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (VALID[i]) begin : g_impl
            logic set_now;
            logic clr_now;
            assign set_now = hw_event[i] | (force_stb & wdata[i]);
            assign clr_now = clr_stb & wdata[i];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       status_q[i] <= 1'b0;
                else if (set_now) status_q[i] <= 1'b1;
                else if (clr_now) status_q[i] <= 1'b0;
            end

            p_evt_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
                hw_event[i] |=> status_q[i]);
            p_evt_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (hw_event[i] && clr_stb && wdata[i]) |=> status_q[i]);
            p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_stb && wdata[i] && !hw_event[i]) |=> !status_q[i]);
            p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (force_stb && wdata[i]) |=> status_q[i]);
        end else begin : g_rsvd
            assign status_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irqc_mask_bits.sv
module irqc_mask_bits #(
    parameter int unsigned      W     = 32,
    parameter logic [W-1:0]     VALID = 32'h0003_BFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         unmask_stb,
    input  logic         maskset_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);
    logic unused_rsvd_in;
    assign unused_rsvd_in = ^(wdata & ~VALID);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (VALID[i]) begin : g_impl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                       mask_q[i] <= 1'b1;
                else if (maskset_stb && wdata[i]) mask_q[i] <= 1'b1;
                else if (unmask_stb && wdata[i])  mask_q[i] <= 1'b0;
            end

            p_unmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (unmask_stb && wdata[i]) |=> !mask_q[i]);
            p_maskset_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (maskset_stb && wdata[i]) |=> mask_q[i]);
        end else begin : g_rsvd
            assign mask_q[i] = 1'b0;
        end
    end

    p_mask_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!unmask_stb && !maskset_stb) |=> $stable(mask_q));
endmodule

// File: rtl/irqc_read_port.sv
module irqc_read_port
    import irqc_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [SEL_W-1:0] rd_addr,
    input  logic [W-1:0]     status_q,
    input  logic [W-1:0]     mask_q,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] rd_mux;

    always_comb begin
        unique case (rd_addr)
            SEL_STATUS: rd_mux = status_q;
            SEL_MASK:   rd_mux = mask_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    p_cmd_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr >= SEL_UNMASK) |=> (rd_data == '0));
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned         DATA_W = 32,
    parameter logic [DATA_W-1:0]   VALID  = 32'h0003_BFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] hw_event,
    output logic              irq
);
    logic              clr_stb;
    logic              unmask_stb;
    logic              maskset_stb;
    logic              force_stb;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] mask_q;

    irqc_wr_decode u_dec (
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .clr_stb     (clr_stb),
        .unmask_stb  (unmask_stb),
        .maskset_stb (maskset_stb),
        .force_stb   (force_stb)
    );

    irqc_status_bits #(.W(DATA_W), .VALID(VALID)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_stb   (clr_stb),
        .force_stb (force_stb),
        .wdata     (wr_data),
        .hw_event  (hw_event),
        .status_q  (status_q)
    );

    irqc_mask_bits #(.W(DATA_W), .VALID(VALID)) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .unmask_stb  (unmask_stb),
        .maskset_stb (maskset_stb),
        .wdata       (wr_data),
        .mask_q      (mask_q)
    );

    irqc_read_port #(.W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .status_q (status_q),
        .mask_q   (mask_q),
        .rd_data  (rd_data)
    );

    assign irq = |(status_q & ~mask_q);

    p_rsvd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr <= SEL_MASK) |=> ((rd_data & ~VALID) == '0));
    p_masked_force_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && wr_en && wr_addr == SEL_MASKSET && hw_event == '0) |=> !irq);
endmodule

// File: tb/evt_irq_ctrl_bench.sv
`timescale 1ns/1ps
module evt_irq_ctrl_bench;
    localparam logic [31:0] IMPL = 32'h0003_BFFF;

    typedef struct packed {
        logic        we;
        logic [2:0]  waddr;
        logic [31:0] wdata;
        logic [31:0] ev;
        logic [2:0]  raddr;
        logic [31:0] exp;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 32'h0,          32'h0,          3'd1, 32'h0003_BFFF, 1'b0, 4'd4},  // R4 mask reset
        '{1'b1, 3'd1, 32'h0,          32'h0,          3'd1, 32'h0003_BFFF, 1'b0, 4'd4},  // R4 mask not writable
        '{1'b1, 3'd4, 32'h5,          32'h0,          3'd0, 32'h0000_0005, 1'b0, 4'd7},  // R7 force, masked
        '{1'b0, 3'd0, 32'h0,          32'h0,          3'd4, 32'h0,         1'b0, 4'd7},  // R7 reads zero
        '{1'b1, 3'd2, 32'h1,          32'h0,          3'd1, 32'h0003_BFFE, 1'b1, 4'd5},  // R5 unmask, R1 irq
        '{1'b0, 3'd0, 32'h0,          32'h0,          3'd2, 32'h0,         1'b1, 4'd5},  // R5 reads zero
        '{1'b1, 3'd0, 32'h1,          32'h0,          3'd0, 32'h0000_0004, 1'b0, 4'd2},  // R2 w1c, R1 drop
        '{1'b1, 3'd4, 32'hFFFF_FFFF,  32'h0,          3'd0, 32'h0003_BFFF, 1'b1, 4'd3},  // R3 force all
        '{1'b1, 3'd0, 32'hFFFF_FFFF,  32'h0,          3'd0, 32'h0,         1'b0, 4'd2},  // R2 clear all
        '{1'b0, 3'd0, 32'h0,          32'hFFFF_FFFF,  3'd0, 32'h0003_BFFF, 1'b1, 4'd8},  // R8 events, R3
        '{1'b1, 3'd3, 32'h1,          32'h0,          3'd1, 32'h0003_BFFF, 1'b0, 4'd6},  // R6 mask set
        '{1'b0, 3'd0, 32'h0,          32'h0,          3'd3, 32'h0,         1'b0, 4'd6},  // R6 reads zero
        '{1'b1, 3'd0, 32'h2,          32'h2,          3'd0, 32'h0003_BFFF, 1'b0, 4'd9},  // R9 event wins
        '{1'b1, 3'd0, 32'h0003_BFFF,  32'h0,          3'd0, 32'h0,         1'b0, 4'd2},  // R2
        '{1'b0, 3'd0, 32'h0,          32'h0,          3'd7, 32'h0,         1'b0, 4'd10}, // R10 unused addr
        '{1'b1, 3'd2, 32'hFFFF_FFFF,  32'h0,          3'd1, 32'h0,         1'b0, 4'd5},  // R5 unmask all
        '{1'b0, 3'd0, 32'h0,          32'h0000_4000,  3'd0, 32'h0,         1'b0, 4'd3},  // R3 reserved event
        '{1'b0, 3'd0, 32'h0,          32'h0002_0000,  3'd0, 32'h0002_0000, 1'b1, 4'd8}   // R8 top bit, R1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] hw_event = '0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    evt_irq_ctrl u_evt_irq_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .hw_event (hw_event),
        .irq      (irq)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", what, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [2:0] a);
        @(negedge clk);
        wr_en = 1'b0; hw_event = '0; rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic run_vec(input int k);
        vec_t v;
        v = VECS[k];
        @(negedge clk);
        wr_en = v.we; wr_addr = v.waddr; wr_data = v.wdata; hw_event = v.ev; rd_en = 1'b0;
        rd_reg(v.raddr);
        check($sformatf("R%0d vector %0d rd_data", v.req, k), rd_data, v.exp);
        check($sformatf("R1 vector %0d irq", k), {31'b0, irq}, {31'b0, v.exp_irq});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R4: reset state
        check("R4 irq in reset", {31'b0, irq}, 32'h0);
        check("R4 rd_data in reset", rd_data, 32'h0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) run_vec(k);

        // R10: rd_data holds without rd_en while state changes
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'h0000_0F00; rd_en = 1'b0; rd_addr = 3'd0;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        check("R10 hold without rd_en", rd_data, 32'h0002_0000);
        rd_reg(3'd0);
        check("R10 fresh read", rd_data, 32'h0002_0F00);

        // R4: reset in the middle of activity
        check("R1 irq before reset", {31'b0, irq}, 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R4 irq cleared by reset", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        rd_reg(3'd0);
        check("R4 status after reset", rd_data, 32'h0);
        rd_reg(3'd1);
        check("R4 mask after reset", rd_data, IMPL);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule